// File: doc/BRIEF.md
# Instruction Line Fetch Controller

This block sits at the front of an instruction pipeline. It turns a program counter into whole-line reads from an instruction cache and then hands the 32-bit words of that line to a downstream queue, several per cycle. Before it reads, it clears the offset bits of the PC. Each read goes out with a small tag. If the cache refuses a read, the block holds the read until a retry strobe comes. When the line returns, the block stores it and extracts words from the PC onward. It does this until the line ends or a stop condition applies.

A side interface supplies two kinds of hint, each as a PC to match. One marks an instruction predicted taken, together with its target. The other marks an instruction that must serialise what follows it. The downstream queue reports its free slots each cycle, and the rename stage reports how many registers are free. A redirect may arrive in any cycle. It moves the PC and abandons any read still in flight. When a response comes back that no longer matches the current read, the block discards it and counts it.

Top module: `ifetch_line_ctrl`

## Requirements
- R1: After reset, status is idle (code 0), no read is presented, no output is valid and all three counters are zero. The block stays idle with no read until a redirect arrives.
- R2: A redirect sets status to running (code 1) one cycle later. One cycle after that, a read is presented (status 2). Its address is the redirect PC with the low 6 bits cleared, and its tag is one more than the tag of the previous read.
- R3: A presented read that sees `req_ready` low moves status to wait-retry (code 4), with `req_valid` low and the address and tag held. A cycle with `retry_strobe` high presents the same address and tag again in the next cycle. Acceptance then moves status to wait-response (code 3).
- R4: A response whose tag matches arrives in wait-response. The block then stores the line, `resp_data` bits [32k+31:32k] being word k. Status becomes running, or rename-blocked (code 5) when `free_regs` is 0. Any other response is discarded and `drop_cnt` increases by one.
- R5: In running, one cycle later `out_count` words come out, starting at word index PC[5:2], with `out_pc` equal to the PC. The count is the smallest of WIDTH, `q_space`, `free_regs` and the words left in the line. The PC then advances by 4 per word.
- R6: Extraction ends with the instruction whose PC equals `bp_pc` while `bp_taken` is high. That instruction is included, and the next PC is `bp_target`.
- R7: Extraction ends after the instruction whose PC equals `ser_pc` while `ser_valid` is high. The next cycle resumes at the following word.
- R8: When the PC lies outside the stored line, or no line is stored, nothing comes out. A read for the PC's line is presented in the next cycle.
- R9: After a redirect, a response carrying the tag of an abandoned read is discarded and counted, and it is never stored.
- R10: `stall_cnt` grows by one for each cycle spent in status 2, 3 or 4. `blocked_cnt` grows by one for each cycle in status 5. No output is valid after such a cycle.
- R11: Rename-blocked returns to running one cycle after `free_regs` becomes non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redir_valid | input | 1 | Redirect strobe |
| redir_pc | input | 32 | New program counter |
| bp_taken | input | 1 | Predicted-taken hint valid |
| bp_pc | input | 32 | PC of the predicted-taken instruction |
| bp_target | input | 32 | Predicted target |
| ser_valid | input | 1 | Serialise-after hint valid |
| ser_pc | input | 32 | PC of the serialise-after instruction |
| q_space | input | QS_W | Free slots in the downstream queue |
| free_regs | input | REG_W | Free rename registers |
| req_valid | output | 1 | Line read presented |
| req_addr | output | 32 | Line-aligned read address |
| req_tag | output | TAG_W | Read tag |
| req_ready | input | 1 | Cache accepts the read this cycle |
| retry_strobe | input | 1 | Cache can take the refused read again |
| resp_valid | input | 1 | Line response valid |
| resp_tag | input | TAG_W | Tag of the response |
| resp_data | input | LINE_BYTES*8 | Line contents, word 0 in the low bits |
| out_valid | output | 1 | Extracted words valid |
| out_count | output | N_W | Number of words this cycle |
| out_pc | output | 32 | PC of the first word |
| out_words | output | WIDTH*32 | Extracted words, slot 0 in the low bits |
| status | output | 3 | Controller state code |
| stall_cnt | output | CNT_W | Cycles spent waiting on the cache |
| blocked_cnt | output | CNT_W | Cycles spent rename-blocked |
| drop_cnt | output | CNT_W | Discarded responses |

## Verification
Every result is due a fixed number of edges after its cause. Status follows a redirect, refusal, retry or line response by one edge. The read follows a redirect by two edges. Words follow the edge that loads the line by one more edge. The bench drives inputs and samples outputs on the falling edge. It waits for the exact edge where the cache model's response is captured, and checks status and the first output batch on the following falling edges. A monitor compares every emitted word against a queue of expected PCs and computed line contents. After a fixed settling window, the bench compares the batch sizes it logged and the counter deltas with the values worked out from the requirements.

// File: rtl/ifl_pkg.sv
package ifl_pkg;
  typedef enum logic [2:0] {
    FS_IDLE   = 3'd0,
    FS_RUN    = 3'd1,
    FS_REQ    = 3'd2,
    FS_WRESP  = 3'd3,
    FS_WRETRY = 3'd4,
    FS_RBLK   = 3'd5
  } fetch_st_e;
endpackage

// File: rtl/ifl_line_store.sv
// Holds one instruction line; written whole, read through WIDTH word ports.
module ifl_line_store #(
  parameter int WORDS = 16,
  parameter int WIDTH = 4,
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [WORDS*32-1:0]       wr_line,
  input  logic [WIDTH*WIDX_W-1:0]   rd_idx,
  output logic [WIDTH*32-1:0]       rd_words
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < WORDS; k++) mem[k] <= wr_line[k*32 +: 32];
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_rd
    assign rd_words[i*32 +: 32] = mem[rd_idx[i*WIDX_W +: WIDX_W]];
  end
endmodule

// File: rtl/ifl_extract.sv
// Decides how many words leave this cycle and where the PC goes next.
module ifl_extract #(
  parameter int WIDTH = 4,
  parameter int OFF_W = 6,
  parameter int QS_W  = 4,
  parameter int REG_W = 6,
  localparam int N_W    = $clog2(WIDTH + 1),
  localparam int WIDX_W = OFF_W - 2
) (
  input  logic [31:0]             pc,
  input  logic [31:0]             base,
  input  logic                    line_vld,
  input  logic [QS_W-1:0]         q_space,
  input  logic [REG_W-1:0]        free_regs,
  input  logic                    bp_taken,
  input  logic [31:0]             bp_pc,
  input  logic [31:0]             bp_target,
  input  logic                    ser_valid,
  input  logic [31:0]             ser_pc,
  output logic                    miss,
  output logic [N_W-1:0]          take_n,
  output logic [31:0]             next_pc,
  output logic [WIDTH*WIDX_W-1:0] rd_idx
);
  logic        alive;
  logic        taken;
  logic [31:0] spc;
  logic        in_line;

  assign miss = !line_vld || (pc[31:OFF_W] != base[31:OFF_W]);

  always_comb begin
    alive  = 1'b1;
    taken  = 1'b0;
    take_n = '0;
    rd_idx = '0;
    for (int i = 0; i < WIDTH; i++) begin
      spc     = pc + 32'(4 * i);
      in_line = line_vld && (spc[31:OFF_W] == base[31:OFF_W]);
      rd_idx[i*WIDX_W +: WIDX_W] = spc[OFF_W-1:2];
      if (alive && in_line && (int'(q_space) > i) && (int'(free_regs) > i)) begin
        take_n = take_n + N_W'(1);
        if (bp_taken && spc == bp_pc) begin
          taken = 1'b1;
          alive = 1'b0;
        end
        if (ser_valid && spc == ser_pc) alive = 1'b0;
      end else begin
        alive = 1'b0;
      end
    end
  end

  assign next_pc = taken ? bp_target : pc + {{(30-N_W){1'b0}}, take_n, 2'b00};
endmodule

// File: rtl/ifetch_line_ctrl.sv
module ifetch_line_ctrl
  import ifl_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int WIDTH      = 4,
  parameter int TAG_W      = 3,
  parameter int QS_W       = 4,
  parameter int REG_W      = 6,
  parameter int CNT_W      = 16,
  localparam int N_W       = $clog2(WIDTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    redir_valid,
  input  logic [31:0]             redir_pc,
  input  logic                    bp_taken,
  input  logic [31:0]             bp_pc,
  input  logic [31:0]             bp_target,
  input  logic                    ser_valid,
  input  logic [31:0]             ser_pc,
  input  logic [QS_W-1:0]         q_space,
  input  logic [REG_W-1:0]        free_regs,
  output logic                    req_valid,
  output logic [31:0]             req_addr,
  output logic [TAG_W-1:0]        req_tag,
  input  logic                    req_ready,
  input  logic                    retry_strobe,
  input  logic                    resp_valid,
  input  logic [TAG_W-1:0]        resp_tag,
  input  logic [LINE_BYTES*8-1:0] resp_data,
  output logic                    out_valid,
  output logic [N_W-1:0]          out_count,
  output logic [31:0]             out_pc,
  output logic [WIDTH*32-1:0]     out_words,
  output logic [2:0]              status,
  output logic [CNT_W-1:0]        stall_cnt,
  output logic [CNT_W-1:0]        blocked_cnt,
  output logic [CNT_W-1:0]        drop_cnt
);
  localparam int WORDS  = LINE_BYTES / 4;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WIDX_W = OFF_W - 2;
  localparam logic [31:0] OFF_MASK = 32'(LINE_BYTES - 1);

  fetch_st_e          st_q;
  logic [31:0]        pc_q, base_q, raddr_q;
  logic               line_vld_q;
  logic [TAG_W-1:0]   tag_q;
  logic               miss;
  logic [N_W-1:0]     take_n;
  logic [31:0]        next_pc;
  logic [WIDTH*WIDX_W-1:0] rd_idx;
  logic [WIDTH*32-1:0] rd_words;
  logic               resp_hit;
  logic               load;

  assign resp_hit = resp_valid && (resp_tag == tag_q) && (st_q == FS_WRESP);
  assign load     = resp_hit && !redir_valid;

  ifl_extract #(
    .WIDTH(WIDTH), .OFF_W(OFF_W), .QS_W(QS_W), .REG_W(REG_W)
  ) u_extract (
    .pc(pc_q), .base(base_q), .line_vld(line_vld_q),
    .q_space(q_space), .free_regs(free_regs),
    .bp_taken(bp_taken), .bp_pc(bp_pc), .bp_target(bp_target),
    .ser_valid(ser_valid), .ser_pc(ser_pc),
    .miss(miss), .take_n(take_n), .next_pc(next_pc), .rd_idx(rd_idx)
  );

  ifl_line_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
    .clk(clk), .wr_en(load), .wr_line(resp_data),
    .rd_idx(rd_idx), .rd_words(rd_words)
  );

  // Control state, PC and line bookkeeping
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= FS_IDLE;
      pc_q       <= '0;
      base_q     <= '0;
      raddr_q    <= '0;
      line_vld_q <= 1'b0;
      tag_q      <= '0;
      out_valid  <= 1'b0;
      out_count  <= '0;
      out_pc     <= '0;
      out_words  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (redir_valid) begin
        pc_q       <= redir_pc;
        line_vld_q <= 1'b0;
        st_q       <= FS_RUN;
      end else begin
        unique case (st_q)
          FS_RUN: begin
            if (miss) begin
              raddr_q <= pc_q & ~OFF_MASK;
              tag_q   <= tag_q + TAG_W'(1);
              st_q    <= FS_REQ;
            end else if (free_regs == '0) begin
              st_q <= FS_RBLK;
            end else if (take_n != '0) begin
              out_valid <= 1'b1;
              out_count <= take_n;
              out_pc    <= pc_q;
              out_words <= rd_words;
              pc_q      <= next_pc;
            end
          end
          FS_REQ:    st_q <= req_ready ? FS_WRESP : FS_WRETRY;
          FS_WRETRY: if (retry_strobe) st_q <= FS_REQ;
          FS_WRESP: begin
            if (load) begin
              base_q     <= raddr_q;
              line_vld_q <= 1'b1;
              st_q       <= (free_regs == '0) ? FS_RBLK : FS_RUN;
            end
          end
          FS_RBLK:   if (free_regs != '0) st_q <= FS_RUN;
          default:   st_q <= st_q;
        endcase
      end
    end
  end

  // Event counters
  always_ff @(posedge clk) begin
    if (rst) begin
      stall_cnt   <= '0;
      blocked_cnt <= '0;
      drop_cnt    <= '0;
    end else begin
      if (st_q == FS_REQ || st_q == FS_WRESP || st_q == FS_WRETRY)
        stall_cnt <= stall_cnt + CNT_W'(1);
      if (st_q == FS_RBLK)
        blocked_cnt <= blocked_cnt + CNT_W'(1);
      if (resp_valid && !load)
        drop_cnt <= drop_cnt + CNT_W'(1);
    end
  end

  assign req_valid = (st_q == FS_REQ);
  assign req_addr  = raddr_q;
  assign req_tag   = tag_q;
  assign status    = st_q;
endmodule

// File: rtl/ifl_chk.sv
module ifl_chk
  import ifl_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int TAG_W = 3,
  parameter int CNT_W = 16,
  localparam int N_W  = $clog2(WIDTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             redir_valid,
  input logic             retry_strobe,
  input logic             req_valid,
  input logic             req_ready,
  input logic [31:0]      req_addr,
  input logic [TAG_W-1:0] req_tag,
  input logic             resp_valid,
  input logic [2:0]       status,
  input logic             out_valid,
  input logic [N_W-1:0]   out_count,
  input logic [CNT_W-1:0] stall_cnt,
  input logic [CNT_W-1:0] drop_cnt
);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (status == FS_IDLE && !redir_valid) |=> (status == FS_IDLE && !req_valid));
  // R2
  redirect_run_chk: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> status == FS_RUN);
  // R3
  refuse_retry_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !redir_valid) |=> status == FS_WRETRY);
  // R3
  retry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (status == FS_WRETRY && !retry_strobe && !redir_valid)
      |=> (status == FS_WRETRY && $stable(req_addr) && $stable(req_tag)));
  // R4
  stray_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && status != FS_WRESP) |=> drop_cnt == CNT_W'($past(drop_cnt) + 1));
  // R5
  batch_size_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_count != '0 && int'(out_count) <= WIDTH));
  // R10
  stall_count_chk: assert property (@(posedge clk) disable iff (rst)
    (status == FS_REQ || status == FS_WRESP || status == FS_WRETRY)
      |=> (stall_cnt == CNT_W'($past(stall_cnt) + 1) && !out_valid));
endmodule

bind ifetch_line_ctrl ifl_chk #(.WIDTH(WIDTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .redir_valid(redir_valid), .retry_strobe(retry_strobe),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_tag(req_tag),
  .resp_valid(resp_valid), .status(status), .out_valid(out_valid),
  .out_count(out_count), .stall_cnt(stall_cnt), .drop_cnt(drop_cnt)
);

// File: tb/ifetch_line_ctrl_tb_top.sv
module ifetch_line_ctrl_tb_top;
  localparam int WIDTH = 4;
  localparam int TAG_W = 3;
  localparam int QS_W  = 4;
  localparam int REG_W = 6;
  localparam int CNT_W = 16;
  localparam int N_W   = $clog2(WIDTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic redir_valid = 1'b0, bp_taken = 1'b0, ser_valid = 1'b0;
  logic [31:0] redir_pc = '0, bp_pc = '0, bp_target = '0, ser_pc = '0;
  logic [QS_W-1:0]  q_space = 4'd15;
  logic [REG_W-1:0] free_regs = 6'd40;
  logic req_valid, req_ready = 1'b1, retry_strobe = 1'b0, resp_valid = 1'b0;
  logic [31:0] req_addr;
  logic [TAG_W-1:0] req_tag, resp_tag = '0;
  logic [511:0] resp_data = '0;
  logic out_valid;
  logic [N_W-1:0] out_count;
  logic [31:0] out_pc;
  logic [WIDTH*32-1:0] out_words;
  logic [2:0] status;
  logic [CNT_W-1:0] stall_cnt, blocked_cnt, drop_cnt;

  always #2 clk = ~clk;

  ifetch_line_ctrl dut_i (.*);

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  int cnt_log[$];
  logic [31:0] last_req_addr = '0;
  logic [TAG_W-1:0] last_req_tag = '0;
  // cache model controls
  int budget = 0;
  bit refuse = 0, inj_pend = 0;
  logic [TAG_W-1:0] inj_tag = '0;
  bit pend_act = 0;
  int pend_dly = 0;
  logic [TAG_W-1:0] pend_tag = '0;
  logic [31:0] pend_addr = '0;

  function automatic logic [31:0] word_of(logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_C3C3;
  endfunction

  function automatic logic [511:0] line_of(logic [31:0] a);
    logic [511:0] l;
    for (int k = 0; k < 16; k++) l[k*32 +: 32] = word_of({a[31:6], 6'd0} + 32'(4*k));
    return l;
  endfunction

  task automatic check(bit ok, string req, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push_range(logic [31:0] a, int n);
    for (int k = 0; k < n; k++) exp_q.push_back(a + 32'(4*k));
  endtask

  task automatic check_log(string req, int e[$]);
    check(cnt_log.size() == e.size(), req, cnt_log.size(), e.size());
    for (int k = 0; k < e.size() && k < cnt_log.size(); k++)
      check(cnt_log[k] == e[k], req, cnt_log[k], e[k]);
  endtask

  // called at a falling edge; returns at the falling edge after the capture
  task automatic redirect(logic [31:0] a);
    redir_valid = 1'b1;
    redir_pc = a;
    @(negedge clk);
    redir_valid = 1'b0;
  endtask

  task automatic inject(logic [TAG_W-1:0] t);
    inj_tag = t;
    inj_pend = 1;
    wait (!inj_pend);
  endtask

  // cache model
  initial begin
    forever begin
      @(negedge clk);
      resp_valid = 1'b0;
      if (pend_act && pend_dly == 0) begin
        resp_valid = 1'b1;
        resp_tag   = pend_tag;
        resp_data  = line_of(pend_addr);
        pend_act   = 0;
      end else begin
        if (pend_act) pend_dly--;
        if (inj_pend) begin
          resp_valid = 1'b1;
          resp_tag   = inj_tag;
          resp_data  = line_of(32'hDEAD_0000);
          inj_pend   = 0;
        end
      end
      req_ready = !refuse;
      if (!rst && req_valid && req_ready && budget > 0) begin
        pend_act  = 1;
        pend_dly  = 1;
        pend_tag  = req_tag;
        pend_addr = req_addr;
        budget--;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && req_valid) begin
        last_req_addr = req_addr;
        last_req_tag  = req_tag;
      end
      if (!rst && out_valid) begin
        cnt_log.push_back(int'(out_count));
        for (int j = 0; j < int'(out_count); j++) begin
          logic [31:0] p, e;
          p = out_pc + 32'(4*j);
          if (exp_q.size() == 0) begin
            check(0, "R5 unexpected word", p, 0);
          end else begin
            e = exp_q.pop_front();
            check(p == e, "R5 word pc", p, e);
            check(out_words[j*32 +: 32] == word_of(e), "R5 word data", out_words[j*32 +: 32], word_of(e));
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(status == 3'd0, "R1 status", status, 0);
    check(!req_valid && !out_valid, "R1 idle outputs", {req_valid, out_valid}, 0);
    check(stall_cnt == 0 && blocked_cnt == 0 && drop_cnt == 0, "R1 counters", stall_cnt, 0);
    repeat (5) @(negedge clk);
    check(status == 3'd0 && !req_valid, "R1 stays idle", status, 0);

    // Test A: plain line, extraction to line end, next-line request
    budget = 1;
    cnt_log.delete();
    push_range(32'h1000_0008, 14);
    redirect(32'h1000_0008);
    check(status == 3'd1, "R2 run after redirect", status, 1);
    @(negedge clk);
    check(req_valid, "R2 request presented", req_valid, 1);
    check(req_addr == 32'h1000_0000, "R2 aligned address", req_addr, 32'h1000_0000);
    check(req_tag == 3'd1, "R2 tag increment", req_tag, 1);
    do @(posedge clk); while (!resp_valid);
    @(negedge clk);
    check(status == 3'd1, "R4 running after line", status, 1);
    @(negedge clk);
    check(out_valid && out_count == 3'd4 && out_pc == 32'h1000_0008, "R5 first batch",
          {out_valid, out_count}, {1'b1, 3'd4});
    repeat (10) @(negedge clk);
    check_log("R5 batches", '{4, 4, 4, 2});
    check(exp_q.size() == 0, "R5 all words", exp_q.size(), 0);
    check(status == 3'd3, "R8 waiting next line", status, 3);
    check(last_req_addr == 32'h1000_0040 && last_req_tag == 3'd2, "R8 next line request",
          last_req_addr, 32'h1000_0040);
    s = stall_cnt;
    repeat (3) @(negedge clk);
    check(stall_cnt == s + 3, "R10 stall count", stall_cnt, s + 3);
    check(!out_valid, "R10 no output while waiting", out_valid, 0);

    // Test B: mismatched and stale responses, predicted-taken branch
    s = drop_cnt;
    inject(3'd1);
    repeat (3) @(negedge clk);
    check(drop_cnt == s + 1, "R4 mismatch dropped", drop_cnt, s + 1);
    check(status == 3'd3, "R4 still waiting", status, 3);
    bp_taken = 1'b1;
    bp_pc = 32'h2000_0008;
    bp_target = 32'h2000_0030;
    budget = 1;
    cnt_log.delete();
    push_range(32'h2000_0000, 3);
    push_range(32'h2000_0030, 4);
    s = drop_cnt;
    redirect(32'h2000_0000);
    inject(3'd2);
    repeat (20) @(negedge clk);
    check(drop_cnt == s + 1, "R9 stale response dropped", drop_cnt, s + 1);
    check_log("R6 taken batches", '{3, 4});
    check(exp_q.size() == 0, "R6 all words", exp_q.size(), 0);
    check(last_req_addr == 32'h2000_0040 && last_req_tag == 3'd4, "R8 after target",
          last_req_addr, 32'h2000_0040);
    bp_taken = 1'b0;

    // Test C: refused request, retry, serialise-after stop
    refuse = 1;
    ser_valid = 1'b1;
    ser_pc = 32'h3000_0014;
    budget = 1;
    cnt_log.delete();
    push_range(32'h3000_0010, 12);
    redirect(32'h3000_0010);
    check(status == 3'd1, "R2 run after redirect", status, 1);
    @(negedge clk);
    check(req_valid, "R3 request presented", req_valid, 1);
    @(negedge clk);
    check(status == 3'd4 && !req_valid, "R3 wait-retry", status, 4);
    repeat (3) @(negedge clk);
    check(status == 3'd4, "R3 held in wait-retry", status, 4);
    refuse = 0;
    retry_strobe = 1'b1;
    @(negedge clk);
    retry_strobe = 1'b0;
    check(req_valid && req_addr == 32'h3000_0000, "R3 replay address", req_addr, 32'h3000_0000);
    check(req_tag == 3'd5, "R3 replay tag", req_tag, 5);
    @(negedge clk);
    check(status == 3'd3, "R3 accepted", status, 3);
    repeat (20) @(negedge clk);
    check_log("R7 serialise batches", '{2, 4, 4, 2});
    check(exp_q.size() == 0, "R7 all words", exp_q.size(), 0);
    ser_valid = 1'b0;

    // Test D: rename-blocked, queue and register limits
    free_regs = 6'd0;
    q_space = 4'd2;
    budget = 1;
    cnt_log.delete();
    redirect(32'h4000_0000);
    repeat (10) @(negedge clk);
    check(status == 3'd5, "R4 rename-blocked on load", status, 5);
    check(cnt_log.size() == 0, "R11 no output while blocked", cnt_log.size(), 0);
    s = blocked_cnt;
    repeat (3) @(negedge clk);
    check(blocked_cnt == s + 3, "R10 blocked count", blocked_cnt, s + 3);
    push_range(32'h4000_0000, 16);
    free_regs = 6'd3;
    @(negedge clk);
    check(status == 3'd1, "R11 leaves rename-blocked", status, 1);
    repeat (15) @(negedge clk);
    check_log("R5 limited batches", '{2, 2, 2, 2, 2, 2, 2, 2});
    check(exp_q.size() == 0, "R5 all words limited", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule